// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit executes the four bit-test operations of an integer datapath on a 16-bit register operand: plain test, test-and-set, test-and-reset and test-and-complement. Each request carries the operand word, a bit index that comes either from a second register or from an 8-bit immediate, a 2-bit operation code, the identifier of the register that holds the operand, and the current flag vector.

One cycle after a valid request the unit presents a registered result. The result holds the old value of the selected bit as the carry flag, the modified word, a write-back enable with the destination register identifier, and the flag vector with only the carry position replaced. A flag update mask marks which flags the result changes. Decode, memory operands and the other arithmetic flags belong to neighbouring logic.

Top module: `bit_modify_unit`

## Requirements
- R1: `rsp_carry` equals the bit of the request word at the selected index, taken before any change is made to the word.
- R2: With `req_idx_sel` = 1 the index is the low 4 bits of `req_idx_imm`, and bits 7..4 of the immediate have no effect on any output.
- R3: With `req_idx_sel` = 0 the index is the low 4 bits of `req_idx_reg`, and bits 15..4 of that register have no effect on any output.
- R4: Operation code 2'b01 (set) returns the word with the selected bit forced to 1 and every other bit unchanged.
- R5: Operation code 2'b10 (reset) returns the word with the selected bit forced to 0 and every other bit unchanged.
- R6: Operation code 2'b11 (complement) returns the word with the selected bit inverted and every other bit unchanged.
- R7: Operation code 2'b00 (test) never asserts `rsp_wb_en`, and its returned word equals the request word.
- R8: For operation codes 2'b01, 2'b10 and 2'b11, `rsp_wb_en` is 1 and `rsp_wb_dst` equals the `req_dst` of the request, so the result returns to the register that held the operand.
- R9: `rsp_flags` equals `req_flags` in every bit except bit 0 (the carry position), which carries `rsp_carry`; `rsp_flag_mask` is 8'h01 on a valid result and 0 otherwise.
- R10: Results appear exactly one clock after the request: `rsp_valid` equals `req_valid` of the previous cycle, and a cycle without a request gives `rsp_valid` = 0 and `rsp_wb_en` = 0.
- R11: An active-low reset clears `rsp_valid`, `rsp_carry`, `rsp_word`, `rsp_wb_en`, `rsp_wb_dst`, `rsp_flags` and `rsp_flag_mask` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 test, 01 set, 10 reset, 11 complement |
| req_idx_sel | input | 1 | 0 takes the index from the register, 1 from the immediate |
| req_word | input | 16 | Operand word |
| req_idx_reg | input | 16 | Register holding the bit index |
| req_idx_imm | input | 8 | Immediate bit index |
| req_dst | input | 4 | Identifier of the register that holds the operand |
| req_flags | input | 8 | Current flag vector |
| rsp_valid | output | 1 | Result valid |
| rsp_carry | output | 1 | Old value of the selected bit |
| rsp_word | output | 16 | Word after the operation |
| rsp_wb_en | output | 1 | Write the word back to the destination |
| rsp_wb_dst | output | 4 | Destination register identifier |
| rsp_flags | output | 8 | Flag vector with carry replaced |
| rsp_flag_mask | output | 8 | Flags the result updates |

## Verification
On every cycle the assertions check the one-cycle latency of the valid, that the carry matches the old bit at the masked index, that at most one bit of the word differs from the operand, that a test never writes back, that the destination is echoed, and that only the carry flag moves. The bench's scenarios are what show the exact result value of each operation code, that the upper index bits of both sources are really ignored, the ends of the index range at bits 0 and 15, the idle gap between requests and the state after reset.

// File: rtl/bit_test_pkg.sv
package bit_test_pkg;

   typedef enum logic [1:0] {
      BT_TEST = 2'b00,
      BT_SET  = 2'b01,
      BT_CLR  = 2'b10,
      BT_FLIP = 2'b11
   } bt_op_e;

   function automatic logic bt_op_writes(bt_op_e op);
      return op != BT_TEST;
   endfunction

endpackage

// File: rtl/bit_index_sel.sv
module bit_index_sel #(
   parameter int unsigned REG_W = 16,
   parameter int unsigned IMM_W = 8,
   parameter int unsigned IDX_W = 4
) (
   input  logic             use_imm,
   input  logic [REG_W-1:0] reg_src,
   input  logic [IMM_W-1:0] imm_src,
   output logic [IDX_W-1:0] bit_idx
);

   generate
      if (IDX_W >= IMM_W || IDX_W >= REG_W) begin : g_bad_width
         $error("bit_index_sel: index width must be narrower than both sources");
      end
   endgenerate

   // Only the low index bits of either source select the bit; the rest are dropped.
   logic [REG_W-IDX_W-1:0] reg_hi;
   logic [IMM_W-IDX_W-1:0] imm_hi;
   logic                   unused_hi;

   assign reg_hi    = reg_src[REG_W-1:IDX_W];
   assign imm_hi    = imm_src[IMM_W-1:IDX_W];
   assign unused_hi = ^{reg_hi, imm_hi};

   assign bit_idx = use_imm ? imm_src[IDX_W-1:0] : reg_src[IDX_W-1:0];

endmodule

// File: rtl/bit_modify_core.sv
module bit_modify_core
   import bit_test_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned IDX_W      = $clog2(DATA_W),
   parameter int unsigned MASK_STYLE = 0
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic [IDX_W-1:0]  bit_idx,
   input  bt_op_e            op,
   output logic              old_bit,
   output logic [DATA_W-1:0] word_out
);

   logic [DATA_W-1:0] sel_mask;

   generate
      if (MASK_STYLE == 0) begin : g_decode
         for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign sel_mask[b] = (bit_idx == IDX_W'(b));
         end
      end else if (MASK_STYLE == 1) begin : g_shift
         assign sel_mask = DATA_W'(1) << bit_idx;
      end else begin : g_bad_style
         $error("bit_modify_core: MASK_STYLE must be 0 or 1");
      end
   endgenerate

   assign old_bit = |(word_in & sel_mask);

   always_comb begin
      unique case (op)
         BT_SET:  word_out = word_in | sel_mask;
         BT_CLR:  word_out = word_in & ~sel_mask;
         BT_FLIP: word_out = word_in ^ sel_mask;
         default: word_out = word_in;
      endcase
   end

endmodule

// File: rtl/bit_flag_merge.sv
module bit_flag_merge #(
   parameter int unsigned FLAG_W    = 8,
   parameter int unsigned CARRY_POS = 0
) (
   input  logic              carry,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out,
   output logic [FLAG_W-1:0] upd_mask
);

   generate
      if (CARRY_POS >= FLAG_W) begin : g_bad_pos
         $error("bit_flag_merge: carry position outside the flag vector");
      end
      for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
         if (f == CARRY_POS) begin : g_carry
            assign flags_out[f] = carry;
            assign upd_mask[f]  = 1'b1;
         end else begin : g_pass
            assign flags_out[f] = flags_in[f];
            assign upd_mask[f]  = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
   import bit_test_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned IMM_W      = 8,
   parameter int unsigned REG_AW     = 4,
   parameter int unsigned FLAG_W     = 8,
   parameter int unsigned CARRY_POS  = 0,
   parameter int unsigned MASK_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic              req_idx_sel,
   input  logic [DATA_W-1:0] req_word,
   input  logic [DATA_W-1:0] req_idx_reg,
   input  logic [IMM_W-1:0]  req_idx_imm,
   input  logic [REG_AW-1:0] req_dst,
   input  logic [FLAG_W-1:0] req_flags,
   output logic              rsp_valid,
   output logic              rsp_carry,
   output logic [DATA_W-1:0] rsp_word,
   output logic              rsp_wb_en,
   output logic [REG_AW-1:0] rsp_wb_dst,
   output logic [FLAG_W-1:0] rsp_flags,
   output logic [FLAG_W-1:0] rsp_flag_mask
);

   localparam int unsigned IDX_W = $clog2(DATA_W);

   generate
      if ((1 << IDX_W) != DATA_W) begin : g_bad_data_w
         $error("bit_modify_unit: DATA_W must be a power of two");
      end
   endgenerate

   bt_op_e            op;
   logic [IDX_W-1:0]  bit_idx;
   logic              old_bit;
   logic [DATA_W-1:0] new_word;
   logic [FLAG_W-1:0] new_flags;
   logic [FLAG_W-1:0] upd_mask;

   assign op = bt_op_e'(req_op);

   bit_index_sel #(
      .REG_W (DATA_W),
      .IMM_W (IMM_W),
      .IDX_W (IDX_W)
   ) u_idx (
      .use_imm (req_idx_sel),
      .reg_src (req_idx_reg),
      .imm_src (req_idx_imm),
      .bit_idx (bit_idx)
   );

   bit_modify_core #(
      .DATA_W     (DATA_W),
      .IDX_W      (IDX_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_core (
      .word_in  (req_word),
      .bit_idx  (bit_idx),
      .op       (op),
      .old_bit  (old_bit),
      .word_out (new_word)
   );

   bit_flag_merge #(
      .FLAG_W    (FLAG_W),
      .CARRY_POS (CARRY_POS)
   ) u_flags (
      .carry     (old_bit),
      .flags_in  (req_flags),
      .flags_out (new_flags),
      .upd_mask  (upd_mask)
   );

   // Single registered result stage; data fields load only with a request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_carry     <= 1'b0;
         rsp_word      <= '0;
         rsp_wb_en     <= 1'b0;
         rsp_wb_dst    <= '0;
         rsp_flags     <= '0;
         rsp_flag_mask <= '0;
      end else begin
         rsp_valid     <= req_valid;
         rsp_wb_en     <= req_valid & bt_op_writes(op);
         rsp_flag_mask <= req_valid ? upd_mask : '0;
         if (req_valid) begin
            rsp_carry  <= old_bit;
            rsp_word   <= new_word;
            rsp_wb_dst <= req_dst;
            rsp_flags  <= new_flags;
         end
      end
   end

endmodule

// File: rtl/bit_modify_unit_chk.sv
module bit_modify_unit_chk #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned IMM_W     = 8,
   parameter int unsigned REG_AW    = 4,
   parameter int unsigned FLAG_W    = 8,
   parameter int unsigned CARRY_POS = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic              req_idx_sel,
   input logic [DATA_W-1:0] req_word,
   input logic [DATA_W-1:0] req_idx_reg,
   input logic [IMM_W-1:0]  req_idx_imm,
   input logic [REG_AW-1:0] req_dst,
   input logic [FLAG_W-1:0] req_flags,
   input logic              rsp_valid,
   input logic              rsp_carry,
   input logic [DATA_W-1:0] rsp_word,
   input logic              rsp_wb_en,
   input logic [REG_AW-1:0] rsp_wb_dst,
   input logic [FLAG_W-1:0] rsp_flags,
   input logic [FLAG_W-1:0] rsp_flag_mask
);

   localparam int unsigned IDX_W = $clog2(DATA_W);

   logic [IDX_W-1:0]  chk_idx;
   logic [FLAG_W-1:0] carry_onehot;
   logic [FLAG_W-1:0] other_flags;

   assign chk_idx      = req_idx_sel ? req_idx_imm[IDX_W-1:0] : req_idx_reg[IDX_W-1:0];
   assign carry_onehot = FLAG_W'(1) << CARRY_POS;
   assign other_flags  = ~carry_onehot;

   p_valid_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   p_carry_old_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid) |-> rsp_carry == $past(req_word[chk_idx]));

   p_single_bit_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid) |-> $countones(rsp_word ^ $past(req_word)) <= 1);

   p_test_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_valid) && $past(req_op) == 2'b00) |-> (!rsp_wb_en && rsp_word == $past(req_word)));

   p_modify_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req_valid) && $past(req_op) != 2'b00) |-> (rsp_wb_en && rsp_wb_dst == $past(req_dst)));

   p_idle_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_wb_en && rsp_flag_mask == '0));

   p_flags_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid) |-> ((rsp_flags & other_flags) == ($past(req_flags) & other_flags)
                            && rsp_flag_mask == carry_onehot));

endmodule

bind bit_modify_unit bit_modify_unit_chk #(
   .DATA_W    (DATA_W),
   .IMM_W     (IMM_W),
   .REG_AW    (REG_AW),
   .FLAG_W    (FLAG_W),
   .CARRY_POS (CARRY_POS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_op        (req_op),
   .req_idx_sel   (req_idx_sel),
   .req_word      (req_word),
   .req_idx_reg   (req_idx_reg),
   .req_idx_imm   (req_idx_imm),
   .req_dst       (req_dst),
   .req_flags     (req_flags),
   .rsp_valid     (rsp_valid),
   .rsp_carry     (rsp_carry),
   .rsp_word      (rsp_word),
   .rsp_wb_en     (rsp_wb_en),
   .rsp_wb_dst    (rsp_wb_dst),
   .rsp_flags     (rsp_flags),
   .rsp_flag_mask (rsp_flag_mask)
);

// File: tb/bit_modify_unit_bench.sv
module bit_modify_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic        req_idx_sel = 1'b0;
   logic [15:0] req_word = '0;
   logic [15:0] req_idx_reg = '0;
   logic [7:0]  req_idx_imm = '0;
   logic [3:0]  req_dst = '0;
   logic [7:0]  req_flags = '0;
   logic        rsp_valid;
   logic        rsp_carry;
   logic [15:0] rsp_word;
   logic        rsp_wb_en;
   logic [3:0]  rsp_wb_dst;
   logic [7:0]  rsp_flags;
   logic [7:0]  rsp_flag_mask;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bit_modify_unit u_bit_modify_unit (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
      .req_idx_sel (req_idx_sel), .req_word (req_word), .req_idx_reg (req_idx_reg),
      .req_idx_imm (req_idx_imm), .req_dst (req_dst), .req_flags (req_flags),
      .rsp_valid (rsp_valid), .rsp_carry (rsp_carry), .rsp_word (rsp_word),
      .rsp_wb_en (rsp_wb_en), .rsp_wb_dst (rsp_wb_dst), .rsp_flags (rsp_flags),
      .rsp_flag_mask (rsp_flag_mask)
   );

   function automatic int exp_idx(logic sel, logic [15:0] r, logic [7:0] i);
      return sel ? int'(i % 16) : int'(r % 16);
   endfunction

   function automatic logic [15:0] exp_word(logic [1:0] op, logic [15:0] w, int k);
      logic [15:0] m = 16'(1) << k;
      case (op)
         2'b01:   return w | m;
         2'b10:   return w & ~m;
         2'b11:   return w ^ m;
         default: return w;
      endcase
   endfunction

   task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a negedge: applies one request, checks its result at the next negedge.
   task automatic run_op(logic [1:0] op, logic sel, logic [15:0] w, logic [15:0] r,
                         logic [7:0] im, logic [3:0] d, logic [7:0] f);
      int k;
      logic [15:0] ew;
      req_valid = 1'b1; req_op = op; req_idx_sel = sel; req_word = w;
      req_idx_reg = r; req_idx_imm = im; req_dst = d; req_flags = f;
      k  = exp_idx(sel, r, im);
      ew = exp_word(op, w, k);
      @(negedge clk);
      cmp("R10 valid", 32'(rsp_valid), 32'd1);
      cmp(sel ? "R1/R2 carry" : "R1/R3 carry", 32'(rsp_carry), 32'(w[k]));
      case (op)
         2'b01:   cmp("R4 set word", 32'(rsp_word), 32'(ew));
         2'b10:   cmp("R5 reset word", 32'(rsp_word), 32'(ew));
         2'b11:   cmp("R6 complement word", 32'(rsp_word), 32'(ew));
         default: cmp("R7 test word", 32'(rsp_word), 32'(ew));
      endcase
      if (op == 2'b00) cmp("R7 test wb_en", 32'(rsp_wb_en), 32'd0);
      else begin
         cmp("R8 wb_en", 32'(rsp_wb_en), 32'd1);
         cmp("R8 wb_dst", 32'(rsp_wb_dst), 32'(d));
      end
      cmp("R9 flags", 32'(rsp_flags), 32'({f[7:1], w[k]}));
      cmp("R9 mask", 32'(rsp_flag_mask), 32'h01);
   endtask

   initial begin
      void'($urandom(32'h1b7e_5a03));
      repeat (3) @(negedge clk);
      cmp("R11 reset valid", 32'(rsp_valid), 32'd0);
      cmp("R11 reset word", 32'(rsp_word), 32'd0);
      cmp("R11 reset carry/wb", 32'({rsp_carry, rsp_wb_en, rsp_wb_dst}), 32'd0);
      cmp("R11 reset flags", 32'({rsp_flags, rsp_flag_mask}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      run_op(2'b01, 1'b1, 16'h0000, 16'h0000, 8'hF3, 4'd5, 8'hAA); // R2: upper imm bits ignored
      run_op(2'b10, 1'b0, 16'hFFFF, 16'hFFF7, 8'h00, 4'd9, 8'h55); // R3: upper reg bits ignored
      run_op(2'b11, 1'b0, 16'h8000, 16'h000F, 8'h0C, 4'd1, 8'hFF); // bit 15 end
      run_op(2'b11, 1'b1, 16'h0001, 16'h0005, 8'h10, 4'd2, 8'h00); // bit 0 end, imm 0x10 -> 0
      run_op(2'b00, 1'b0, 16'hFFFF, 16'h1234, 8'hFF, 4'd7, 8'h7E); // R7 test on all-ones
      run_op(2'b01, 1'b1, 16'hFFFF, 16'h0000, 8'h07, 4'd3, 8'h01); // R4 set already-set bit
      // R10: idle gap
      req_valid = 1'b0;
      @(negedge clk);
      cmp("R10 idle valid", 32'(rsp_valid), 32'd0);
      cmp("R10 idle wb_en", 32'(rsp_wb_en), 32'd0);
      cmp("R9 idle mask", 32'(rsp_flag_mask), 32'd0);
      for (int n = 0; n < 600; n++) begin
         run_op(2'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                8'($urandom), 4'($urandom), 8'($urandom));
         if (($urandom % 8) == 0) begin
            req_valid = 1'b0;
            @(negedge clk);
            cmp("R10 gap valid", 32'({rsp_valid, rsp_wb_en}), 32'd0);
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule